// File: doc/BRIEF.md
# Split ROM / SRAM Memory Subsystem

This block is a 4096-word by 8-bit memory built from four equal banks of 1024 words each. The lowest bank is fixed read-only storage. Its contents are produced by a constant function inside the RTL, so no loader is needed. The three upper banks are static RAM that can be read and written. A small decoder on the two top address bits picks one bank. A read multiplexer returns the word held by that bank.

A client drives a 12-bit address, an active-high chip enable and a read/not-write line (1 = read, 0 = write). Reads are combinational: the word appears on the read bus in the same cycle as the address. Writes are committed on the rising clock edge. A write aimed at the read-only range is discarded without disturbing any bank. Whenever the block is not performing a read, the read bus is held at zero.

Top module: `mixed_rom_sram_mem`

## Requirements
- R1: Address bits [11:10] choose the bank: 00 is the read-only bank (addresses 0..1023); 01, 10 and 11 are RAM banks covering 1024..2047, 2048..3071 and 3072..4095. Bits [9:0] select the word inside the bank.
- R2: The read-only word at address a (0..1023) is 8'hA5 XOR a[7:0] XOR {a[9:8], 6'b000000}.
- R3: When chip enable is 1 and read/not-write is 0 at a rising clock edge, and the address is in 1024..4095, the write data is stored at that address.
- R4: When chip enable is 1 and read/not-write is 1, the read bus shows the word at the current address in the same cycle, with no clock edge needed.
- R5: A write to an address in 0..1023 changes no bank: the read-only word and the RAM words at the same in-bank offset all read back unchanged.
- R6: The read bus is 0 whenever chip enable is 0 or read/not-write is 0.
- R7: A write request with chip enable at 0 stores nothing.
- R8: The banks do not alias one another. Adjacent addresses across a bank boundary (1023/1024) and the same offset in different RAM banks hold independent words. The top address 4095 is writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; RAM writes take effect on its rising edge |
| ce | input | 1 | Chip enable, active high |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 12 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; zero when no read is in progress |

## Verification
The hardest case to reach is a discarded write to the read-only range. A wrong decode there would not corrupt the read-only word itself. It would instead land in a RAM bank at the same in-bank offset. To expose this, the stimulus first fills offset 1023 of every RAM bank with a distinct value. It then writes to address 1023 and reads back all four addresses that share that offset. A second hidden case is a write issued with chip enable low. It is followed at once by a read of the targeted address.

// File: rtl/mem_split_pkg.sv
package mem_split_pkg;

   // Fixed image of the read-only bank, computed rather than tabulated.
   function automatic logic [31:0] rom_word(input logic [31:0] idx);
      logic [31:0] v;
      v = 32'h0000_00A5 ^ {24'd0, idx[7:0]} ^ {24'd0, idx[9:8], 6'd0};
      return v;
   endfunction

   function automatic int unsigned ceil_log2(input int unsigned n);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < n) r++;
      return r;
   endfunction

endpackage

// File: rtl/msm_bank_decode.sv
module msm_bank_decode #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned SEL_W     = 2
) (
   input  logic                 ce,
   input  logic [SEL_W-1:0]     bank_idx,
   output logic [NUM_BANKS-1:0] bank_sel
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign bank_sel[b] = ce && (bank_idx == SEL_W'(b));
   end

endmodule

// File: rtl/msm_rom_bank.sv
module msm_rom_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OFF_W  = 10,
   parameter int unsigned BANK   = 0
) (
   input  logic [OFF_W-1:0]  offset,
   output logic [DATA_W-1:0] q
);
   import mem_split_pkg::*;

   localparam int unsigned DEPTH = 1 << OFF_W;

   logic [DATA_W-1:0] image [DEPTH];

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         image[i] = DATA_W'(rom_word(32'(BANK * DEPTH + i)));
      end
   end

   assign q = image[offset];

endmodule

// File: rtl/msm_sram_bank.sv
module msm_sram_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OFF_W  = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   localparam int unsigned DEPTH = 1 << OFF_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[offset] <= wdata;
   end

   assign q = store[offset];

endmodule

// File: rtl/msm_read_mux.sv
module msm_read_mux #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_BANKS = 4
) (
   input  logic                              rd_en,
   input  logic [NUM_BANKS-1:0]              bank_sel,
   input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_q,
   output logic [DATA_W-1:0]                 rdata
);

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         rdata |= bank_q[b] & {DATA_W{rd_en & bank_sel[b]}};
      end
   end

endmodule

// File: rtl/mixed_rom_sram_mem.sv
module mixed_rom_sram_mem #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned OFF_W     = 10,
   parameter int unsigned ROM_BANKS = 1
) (
   input  logic              clk,
   input  logic              ce,
   input  logic              rd_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned SEL_W     = ADDR_W - OFF_W;
   localparam int unsigned NUM_BANKS = 1 << SEL_W;

   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed OFF_W");
   end
   if (ROM_BANKS > NUM_BANKS) begin : g_bad_rom
      $error("ROM_BANKS exceeds bank count");
   end
   if (DATA_W == 0) begin : g_bad_data
      $error("DATA_W must be nonzero");
   end

   logic [SEL_W-1:0]                bank_idx;
   logic [OFF_W-1:0]                offset;
   logic [NUM_BANKS-1:0]            bank_sel;
   logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
   logic                            wr_req;
   logic                            rd_en;

   assign bank_idx = addr[ADDR_W-1 -: SEL_W];
   assign offset   = addr[OFF_W-1:0];
   assign wr_req   = ce & ~rd_wr_n;
   assign rd_en    = ce & rd_wr_n;

   msm_bank_decode #(
      .NUM_BANKS(NUM_BANKS),
      .SEL_W    (SEL_W)
   ) u_dec (
      .ce      (ce),
      .bank_idx(bank_idx),
      .bank_sel(bank_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (b < ROM_BANKS) begin : g_rom
         msm_rom_bank #(
            .DATA_W(DATA_W),
            .OFF_W (OFF_W),
            .BANK  (b)
         ) u_rom (
            .offset(offset),
            .q     (bank_q[b])
         );
      end else begin : g_ram
         msm_sram_bank #(
            .DATA_W(DATA_W),
            .OFF_W (OFF_W)
         ) u_ram (
            .clk   (clk),
            .we    (wr_req & bank_sel[b]),
            .offset(offset),
            .wdata (wdata),
            .q     (bank_q[b])
         );
      end
   end

   msm_read_mux #(
      .DATA_W   (DATA_W),
      .NUM_BANKS(NUM_BANKS)
   ) u_mux (
      .rd_en   (rd_en),
      .bank_sel(bank_sel),
      .bank_q  (bank_q),
      .rdata   (rdata)
   );

endmodule

// File: rtl/msm_checker.sv
module msm_checker #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned OFF_W     = 10,
   parameter int unsigned NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 ce,
   input logic                 rd_wr_n,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wdata,
   input logic [DATA_W-1:0]    rdata,
   input logic [NUM_BANKS-1:0] bank_sel
);
   import mem_split_pkg::*;

   logic [1:0] warm = 2'd0;
   always_ff @(posedge clk) begin
      if (warm != 2'd3) warm <= warm + 2'd1;
   end
   logic live;
   assign live = (warm == 2'd3);

   logic in_ram;
   assign in_ram = (addr[ADDR_W-1:OFF_W] != '0);

   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!live)
      !(ce && rd_wr_n) |-> rdata == '0);                                   // R6

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!live)
      ce |-> $countones(bank_sel) == 1);                                  // R1

   AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!live)
      !ce |-> bank_sel == '0);                                            // R1

   AST_ROM_IMAGE: assert property (@(posedge clk) disable iff (!live)
      (ce && rd_wr_n && !in_ram) |-> rdata == DATA_W'(rom_word(32'(addr)))); // R2

   AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!live)
      (ce && !rd_wr_n && in_ram) |=>
         ((ce && rd_wr_n && addr == $past(addr)) -> rdata == $past(wdata))); // R3

   AST_READ_STABLE: assert property (@(posedge clk) disable iff (!live)
      (ce && rd_wr_n && $past(ce && rd_wr_n) && $stable(addr)) |-> $stable(rdata)); // R4

endmodule

bind mixed_rom_sram_mem msm_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .OFF_W    (OFF_W),
   .NUM_BANKS(NUM_BANKS)
) u_chk (
   .clk     (clk),
   .ce      (ce),
   .rd_wr_n (rd_wr_n),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .bank_sel(bank_sel)
);

// File: tb/sim_mixed_rom_sram_mem.sv
module sim_mixed_rom_sram_mem;

   // op codes: 0 write, 1 read+check, 2 read with ce low (expect 0), 3 write with ce low
   localparam int NV = 27;
   localparam logic [29:0] VEC [NV] = '{
      {2'd0, 12'h400, 8'h11, 8'h00},
      {2'd0, 12'h800, 8'h22, 8'h00},
      {2'd0, 12'hC00, 8'h33, 8'h00},
      {2'd0, 12'hFFF, 8'h44, 8'h00},
      {2'd0, 12'h7FF, 8'h55, 8'h00},
      {2'd0, 12'hBFF, 8'h77, 8'h00},
      {2'd1, 12'h400, 8'h00, 8'h11},
      {2'd1, 12'h800, 8'h00, 8'h22},
      {2'd1, 12'hC00, 8'h00, 8'h33},
      {2'd1, 12'hFFF, 8'h00, 8'h44},
      {2'd1, 12'h7FF, 8'h00, 8'h55},
      {2'd1, 12'hBFF, 8'h00, 8'h77},
      {2'd1, 12'h000, 8'h00, 8'hA5},
      {2'd1, 12'h100, 8'h00, 8'hE5},
      {2'd1, 12'h3FF, 8'h00, 8'h9A},
      {2'd0, 12'h3FF, 8'h00, 8'h00},
      {2'd1, 12'h3FF, 8'h00, 8'h9A},
      {2'd1, 12'h7FF, 8'h00, 8'h55},
      {2'd1, 12'hBFF, 8'h00, 8'h77},
      {2'd1, 12'hFFF, 8'h00, 8'h44},
      {2'd2, 12'h400, 8'h00, 8'h00},
      {2'd3, 12'h400, 8'hEE, 8'h00},
      {2'd1, 12'h400, 8'h00, 8'h11},
      {2'd0, 12'h401, 8'h66, 8'h00},
      {2'd1, 12'h401, 8'h00, 8'h66},
      {2'd1, 12'h400, 8'h00, 8'h11},
      {2'd1, 12'h3FF, 8'h00, 8'h9A}
   };

   logic        clk = 1'b0;
   logic        ce = 1'b0;
   logic        rd_wr_n = 1'b1;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mixed_rom_sram_mem u0 (
      .clk    (clk),
      .ce     (ce),
      .rd_wr_n(rd_wr_n),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata)
   );

   function automatic logic [7:0] exp_rom(input int a);
      logic [11:0] x;
      x = 12'(a);
      return 8'hA5 ^ x[7:0] ^ {x[9:8], 6'd0};
   endfunction

   task automatic check(input string req, input logic [7:0] exp);
      checks++;
      if (rdata !== exp) begin
         failures++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, rdata, exp);
      end
   endtask

   // drive after falling edge, sample 5 ns later, then cross the rising edge
   task automatic step(input logic [1:0] op, input logic [11:0] a,
                       input logic [7:0] d, input logic [7:0] exp);
      @(negedge clk);
      addr  = a;
      wdata = d;
      case (op)
         2'd0: begin ce = 1'b1; rd_wr_n = 1'b0; end
         2'd1: begin ce = 1'b1; rd_wr_n = 1'b1; end
         2'd2: begin ce = 1'b0; rd_wr_n = 1'b1; end
         default: begin ce = 1'b0; rd_wr_n = 1'b0; end
      endcase
      #5;
      case (op)
         2'd1: check("R4/R3/R5/R7 read", exp);
         default: check("R6 bus zero", 8'h00);
      endcase
      @(posedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // reset state: idle bus reads zero (R6)
      #5;
      check("R6 initial idle", 8'h00);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][29:28], VEC[i][27:16], VEC[i][15:8], VEC[i][7:0]);
      end

      // R2 / R1: full sweep of the read-only image
      for (int a = 0; a < 1024; a++) begin
         @(negedge clk);
         ce = 1'b1; rd_wr_n = 1'b1; addr = 12'(a);
         #5;
         check("R2 rom image", exp_rom(a));
      end

      // R8: boundary 1023/1024 and top address, distinct words per bank
      step(2'd0, 12'h400, 8'hC3, 8'h00);
      step(2'd1, 12'h3FF, 8'h00, exp_rom(1023));   // R8 below boundary
      step(2'd1, 12'h400, 8'h00, 8'hC3);           // R8 above boundary
      step(2'd0, 12'hFFF, 8'h3C, 8'h00);
      step(2'd1, 12'hFFF, 8'h00, 8'h3C);           // R8 top address
      step(2'd1, 12'hBFF, 8'h00, 8'h77);           // R8 same offset, other bank

      // R7: ce-low write to top address then read
      step(2'd3, 12'hFFF, 8'h99, 8'h00);
      step(2'd1, 12'hFFF, 8'h00, 8'h3C);           // R7

      // R5: rom write to offset 0 leaves RAM offset 0 in all banks
      step(2'd0, 12'h000, 8'hFF, 8'h00);
      step(2'd1, 12'h000, 8'h00, 8'hA5);           // R5
      step(2'd1, 12'h800, 8'h00, 8'h22);           // R5
      step(2'd1, 12'hC00, 8'h00, 8'h33);           // R5

      // R6: back to idle
      step(2'd2, 12'h800, 8'h00, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule